// File: doc/BRIEF.md
# Synthesizer Serial Programming Master

This block programs a dual-modulus PLL frequency synthesizer from a channel number. On a start strobe it captures the channel index and adds it to a base divide value. It splits the total divide value into a main count and a swallow count for a divide-by-64 prescaler. It then builds two 19-bit control words and shifts them out over a three-wire clock, load-strobe and data interface.

Both words are sent most significant bit first. The reference word goes first and carries the fixed mode bits and the reference division ratio. The divider word follows and carries the main and swallow counts. The last bit of each word is a tag that tells the synthesizer which register to load. Every setup time, pulse width and gap on the serial pins is made by counting system clock cycles, and the counts are derived from the clock period parameter.

After the second word is loaded, the block waits for a settling interval and then samples the lock-detect input. If lock is not present at that point, it keeps watching for a bounded timeout window. It then drops busy and reports either locked or lock failure.

Top module: `pll_prog_master`

## Requirements
- R1: After reset, ser_clk, ser_le, ser_data, busy, locked and lock_fail are all 0.
- R2: A start pulse while busy is 0 captures chan and sets busy on the next clock edge. A start pulse while busy is 1 is ignored, and the words in flight keep the first channel.
- R3: The first word sent is the reference word, 19 bits, MSB first. Bit 18 is the charge-pump select (0). Bit 17 is the lock-output select (0). Bit 16 is the phase polarity bit (1). Bit 15 is SW_BIT. Bits 14..1 are REF_DIV. Bit 0 is the tag, which is 1.
- R4: The second word is the divider word, with n = BASE_N + chan. Bits 18..8 hold N = floor(n/64). Bits 7..1 hold A = n mod 64, so bit 7 is 0. Bit 0 is the tag, which is 0. For example, BASE_N = 32596 with chan = 18 gives N = 509 and A = 38.
- R5: Each data bit is valid at the rising edge of ser_clk, at least 20 ns after ser_data last changed. ser_le is low at every rising edge of ser_clk. The ser_clk high time is at least 30 ns.
- R6: ser_le rises at least 30 ns after the last rising edge of ser_clk and stays high for at least 30 ns. At least 100 ns pass from the fall of ser_le to the next rising edge of ser_clk. ser_clk and ser_le are never high together.
- R7: After the second word, the block waits about SETTLE_NS. If lock_det is 1 at that point, locked becomes 1 and busy becomes 0 on the same edge. While the block is idle, ser_clk and ser_le stay low.
- R8: If lock_det is 1 during the following TIMEOUT_NS window, the block ends with locked set. If it is not, lock_fail becomes 1 and busy 0. locked and lock_fail are never 1 together, and busy falls only with one of them set.
- R9: An accepted start clears locked and lock_fail on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin programming the channel on chan |
| chan | input | CH_W | Channel index |
| lock_det | input | 1 | Lock-detect signal from the synthesizer |
| ser_clk | output | 1 | Serial shift clock |
| ser_le | output | 1 | Serial load strobe |
| ser_data | output | 1 | Serial data |
| busy | output | 1 | Programming or lock wait in progress |
| locked | output | 1 | Last sequence ended with lock |
| lock_fail | output | 1 | Last sequence timed out without lock |

## Verification
busy rises on the first edge after an accepted start, so the bench checks it at the next falling clock. The serial words are captured on the pin edges themselves. Their timing is measured in nanoseconds between pin transitions rather than at fixed cycles.

Status is due on the same edge at which busy falls. The bench waits for that fall and samples locked and lock_fail half a cycle later. For the timeout case, it counts cycles from the second load strobe to the fall of busy: 3 strobe, 10 gap, 200 settle and 300 timeout cycles, so about 513. For late lock, it raises lock_det inside the timeout window and expects locked two falling edges later.

// File: rtl/pll_prog_master.sv
`timescale 1ns/1ps
module pll_prog_master #(
  parameter int CH_W          = 8,
  parameter int BASE_N        = 32596,
  parameter int REF_DIV       = 1680,
  parameter int PRESC_LOG2    = 6,
  parameter int NDIV_W        = 11,
  parameter int ADIV_W        = 7,
  parameter int RDIV_W        = 14,
  parameter bit SW_BIT        = 1'b0,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SETTLE_NS     = 5000000,
  parameter int TIMEOUT_NS    = 10000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CH_W-1:0] chan,
  input  logic            lock_det,
  output logic            ser_clk,
  output logic            ser_le,
  output logic            ser_data,
  output logic            busy,
  output logic            locked,
  output logic            lock_fail
);
  localparam int WORD_W  = RDIV_W + 5;
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int NW      = NDIV_W + PRESC_LOG2;
  localparam int T_SH    = (30 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int T_LG    = (100 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int T_SET   = (SETTLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int T_OUT   = (TIMEOUT_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam logic [WORD_W-1:0] REF_WORD = {3'b001, SW_BIT, RDIV_W'(REF_DIV), 1'b1};

  typedef enum logic [2:0] {
    S_IDLE, S_BIT_LO, S_BIT_HI, S_LE_SU, S_LE_HI, S_LE_GAP, S_SETTLE, S_POLL
  } state_t;

  state_t            st;
  logic [31:0]       tmr;
  logic [BIT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] sreg;
  logic [CH_W-1:0]   chan_q;
  logic              second;
  logic [NW-1:0]     total_n;
  logic [WORD_W-1:0] div_word;
  logic              tmr_done;

  assign total_n  = NW'(BASE_N) + NW'(chan_q);
  assign div_word = {total_n[NW-1:PRESC_LOG2], ADIV_W'(total_n[PRESC_LOG2-1:0]), 1'b0};
  assign ser_data = sreg[WORD_W-1];
  assign tmr_done = (tmr == 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      bit_idx   <= '0;
      sreg      <= '0;
      chan_q    <= '0;
      second    <= 1'b0;
      ser_clk   <= 1'b0;
      ser_le    <= 1'b0;
      busy      <= 1'b0;
      locked    <= 1'b0;
      lock_fail <= 1'b0;
    end else begin
      if (!tmr_done) tmr <= tmr - 32'd1;
      case (st)
        S_IDLE: if (start) begin
          chan_q    <= chan;
          sreg      <= REF_WORD;
          second    <= 1'b0;
          bit_idx   <= BIT_W'(WORD_W - 1);
          tmr       <= 32'(T_SH - 1);
          busy      <= 1'b1;
          locked    <= 1'b0;
          lock_fail <= 1'b0;
          st        <= S_BIT_LO;
        end
        S_BIT_LO: if (tmr_done) begin
          ser_clk <= 1'b1;
          tmr     <= 32'(T_SH - 1);
          st      <= S_BIT_HI;
        end
        S_BIT_HI: if (tmr_done) begin
          ser_clk <= 1'b0;
          tmr     <= 32'(T_SH - 1);
          if (bit_idx == '0) begin
            st <= S_LE_SU;
          end else begin
            sreg    <= {sreg[WORD_W-2:0], 1'b0};
            bit_idx <= bit_idx - 1'b1;
            st      <= S_BIT_LO;
          end
        end
        S_LE_SU: if (tmr_done) begin
          ser_le <= 1'b1;
          tmr    <= 32'(T_SH - 1);
          st     <= S_LE_HI;
        end
        S_LE_HI: if (tmr_done) begin
          ser_le <= 1'b0;
          tmr    <= 32'(T_LG - 1);
          st     <= S_LE_GAP;
        end
        S_LE_GAP: if (tmr_done) begin
          if (!second) begin
            second  <= 1'b1;
            sreg    <= div_word;
            bit_idx <= BIT_W'(WORD_W - 1);
            tmr     <= 32'(T_SH - 1);
            st      <= S_BIT_LO;
          end else begin
            sreg <= '0;
            tmr  <= 32'(T_SET - 1);
            st   <= S_SETTLE;
          end
        end
        S_SETTLE: if (tmr_done) begin
          if (lock_det) begin
            locked <= 1'b1;
            busy   <= 1'b0;
            st     <= S_IDLE;
          end else begin
            tmr <= 32'(T_OUT - 1);
            st  <= S_POLL;
          end
        end
        S_POLL: begin
          if (lock_det) begin
            locked <= 1'b1;
            busy   <= 1'b0;
            st     <= S_IDLE;
          end else if (tmr_done) begin
            lock_fail <= 1'b1;
            busy      <= 1'b0;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_prog_master_chk.sv
`timescale 1ns/1ps
module pll_prog_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic ser_clk,
  input logic ser_le,
  input logic ser_data,
  input logic locked,
  input logic lock_fail
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_LE_LOW_AT_CLK: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_clk) |-> !ser_le); // R5
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_clk) |-> $stable(ser_data)); // R5
  AST_CLK_LE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ser_clk && ser_le)); // R6
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!ser_clk && !ser_le)); // R7
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(locked && lock_fail)); // R8
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (locked || lock_fail)); // R8
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (!locked && !lock_fail)); // R9
endmodule

bind pll_prog_master pll_prog_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ser_clk(ser_clk),
  .ser_le(ser_le), .ser_data(ser_data), .locked(locked), .lock_fail(lock_fail)
);

// File: tb/test_pll_prog_master.sv
`timescale 1ns/1ps
module test_pll_prog_master;
  localparam int REF = 1680;
  localparam logic [18:0] REF_EXP = {3'b001, 1'b0, 14'(REF), 1'b1};
  // {chan[8], N[11], A[7], mode[2]}; mode 0 = lock present, 1 = never locks
  localparam logic [27:0] VEC [5] = '{
    {8'd0,   11'd509, 7'd20, 2'd0},
    {8'd18,  11'd509, 7'd38, 2'd0},
    {8'd43,  11'd509, 7'd63, 2'd0},
    {8'd44,  11'd510, 7'd0,  2'd1},
    {8'd255, 11'd513, 7'd19, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lock_det = 1'b0;
  logic [7:0] chan = '0;
  logic ser_clk, ser_le, ser_data, busy, locked, lock_fail;
  int tests = 0, fails = 0, cyc = 0;

  pll_prog_master #(.CLK_PERIOD_NS(10), .SETTLE_NS(2000), .TIMEOUT_NS(3000), .REF_DIV(REF))
  i_pll_prog_master (.clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .lock_det(lock_det),
    .ser_clk(ser_clk), .ser_le(ser_le), .ser_data(ser_data), .busy(busy),
    .locked(locked), .lock_fail(lock_fail));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // pin monitors
  logic [18:0] shf = '0;
  logic [18:0] cap [64];
  int ncap = 0, v5 = 0, v6 = 0;
  realtime t_data = 0, t_crise = 0, t_lrise = 0, t_lfall = -1000;
  always @(ser_data) t_data = $realtime;
  always @(posedge ser_clk) begin
    if ($realtime - t_data < 20 || ser_le) v5++;
    if ($realtime - t_lfall < 100) v6++;
    t_crise = $realtime;
    shf = {shf[17:0], ser_data};
  end
  always @(negedge ser_clk) if ($realtime - t_crise < 30) v5++;
  always @(posedge ser_le) begin
    if ($realtime - t_crise < 30 || ser_clk) v6++;
    t_lrise = $realtime;
    cap[ncap % 64] = shf;
    ncap++;
  end
  always @(negedge ser_le) begin
    if ($realtime - t_lrise < 30) v6++;
    t_lfall = $realtime;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] ch);
    @(negedge clk);
    chan = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(output int waited);
    waited = 0;
    while (busy && waited < 5000) begin @(negedge clk); waited++; end
  endtask

  task automatic check_words(input int base, input int n, input int a, input string tag);
    check(ncap == base + 2, {tag, " R3 word count"}, ncap - base, 2);
    check(cap[base % 64] == REF_EXP, {tag, " R3 reference word"}, int'(cap[base % 64]), int'(REF_EXP));
    check(cap[(base + 1) % 64] == {11'(n), 7'(a), 1'b0}, {tag, " R4 divider word"},
          int'(cap[(base + 1) % 64]), int'({11'(n), 7'(a), 1'b0}));
  endtask

  initial begin
    int w, base, b5, b6;
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({ser_clk, ser_le, ser_data, busy, locked, lock_fail} == 6'b0, "R1 reset outputs",
              int'({ser_clk, ser_le, ser_data, busy, locked, lock_fail}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 5; i++) begin
          base = ncap; b5 = v5; b6 = v6;
          lock_det = (VEC[i][1:0] == 2'd0);
          pulse_start(VEC[i][27:20]);
          check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
          wait_idle(w);
          check_words(base, int'(VEC[i][19:9]), int'(VEC[i][8:2]), $sformatf("vec%0d", i));
          check(v5 == b5, "R5 shift timing", v5 - b5, 0);
          check(v6 == b6, "R6 load strobe timing", v6 - b6, 0);
          if (VEC[i][1:0] == 2'd0)
            check(locked && !lock_fail && !busy, "R7 locked at settle", int'({locked, lock_fail}), 2);
          else
            check(!locked && lock_fail && !busy, "R8 timeout reported", int'({locked, lock_fail}), 1);
          repeat (5) @(negedge clk);
          check(!ser_clk && !ser_le, "R7 idle pins low", int'({ser_clk, ser_le}), 0);
        end

        // R9 status cleared by a new start (last vector ended locked; make one fail first)
        lock_det = 1'b0;
        base = ncap;
        pulse_start(8'd2);
        check(!locked && !lock_fail, "R9 status cleared on start", int'({locked, lock_fail}), 0);
        // timeout duration from second strobe
        while (ncap < base + 2) @(negedge clk);
        w = 0;
        while (busy && w < 5000) begin @(negedge clk); w++; end
        check(w >= 510 && w <= 518, "R8 timeout window length", w, 513);
        check(lock_fail && !locked, "R8 fail flag", int'({locked, lock_fail}), 1);
        lock_det = 1'b1;
        pulse_start(8'd3);
        check(!locked && !lock_fail, "R9 fail flag cleared", int'({locked, lock_fail}), 0);
        wait_idle(w);

        // R2 start while busy is ignored
        base = ncap;
        pulse_start(8'd10);
        repeat (50) @(negedge clk);
        pulse_start(8'd200);
        wait_idle(w);
        check_words(base, 509, 30, "ignore R2");
        repeat (3) @(negedge clk);
        check(!busy && ncap == base + 2, "R2 no second sequence", ncap - base, 2);

        // R8 late lock inside the timeout window
        lock_det = 1'b0;
        base = ncap;
        pulse_start(8'd1);
        while (ncap < base + 2) @(negedge clk);
        repeat (260) @(negedge clk);
        check(busy && !lock_fail && !locked, "R8 still waiting in window", int'({busy, locked, lock_fail}), 4);
        lock_det = 1'b1;
        repeat (2) @(negedge clk);
        check(locked && !lock_fail && !busy, "R8 late lock accepted", int'({busy, locked, lock_fail}), 2);
        check_words(base, 509, 21, "late R4");
      end
      begin
        while (cyc < 150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 150000);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule